// File: doc/BRIEF.md
# Frame-Boundary Reconfiguration Gate

This block wraps a streaming video processing core whose parameters cannot be changed while a frame is moving through it. The incoming AXI4-Stream passes through a gate on its way into the core, and the core's output stream is tapped but not altered. When a new parameter word arrives on the request port, the block does not apply it right away. It lets the frame that is already entering the core finish. It then holds back the next start-of-frame beat and waits until the core has emitted every frame it was given. Only then does it reset the core for a programmable number of cycles and load the new parameters into the active register. After one idle cycle it opens the gate again, and the held start-of-frame beat is the first one through.

A frame start on the input is a beat that carries TUSER high. Frames leaving the core are counted by their TLAST beats against a configured lines-per-frame value. That count restarts at every output frame start and at every core reset. The gate never drops a beat: it only stalls the source by keeping TREADY and TVALID low. The busy output tells software when a change is still pending.

Top module: `frame_cfg_gate`

## Requirements
- R1: While no change is pending, the gate is transparent. `m_tvalid` equals `s_tvalid`, `s_tready` equals `m_tready`, and data, TUSER and TLAST pass unchanged in the same cycle.
- R2: Once a request has been accepted, beats with `s_tuser`=0 keep passing. A beat with `s_tuser`=1 is held (`s_tready`=0, `m_tvalid`=0) and does not reach the core until the gate reopens.
- R3: `core_rst` rises only after every frame that entered the core has completed at the output. It rises two cycles after the handshake of the TLAST beat that completes the last outstanding frame.
- R4: `core_rst` stays high for `rst_cycles` consecutive cycles. A value of 0 is treated as 1.
- R5: `cfg_active` changes only on a clock edge at which `core_rst` was high. It is not updated before the core reset has begun.
- R6: After `core_rst` falls, there is exactly one cycle in which the gate stays closed and `busy` stays high. In the cycle after that, the gate is open again.
- R7: `busy` goes high in the cycle after a request is accepted. It stays high until the gate reopens.
- R8: Each request overwrites the stored parameter word. A request that arrives during the core reset is applied by that same reset. A request that arrives in the idle cycle after the reset starts a new change cycle instead of being lost.
- R9: An output frame is complete when the number of output TLAST handshakes reaches `lines_per_frame`. A beat with `o_tuser`=1 restarts the count, so TLAST beats seen before an output frame start do not count toward it.
- R10: No beat is lost or duplicated. A beat is accepted on the slave side exactly when a beat is accepted on the master side.
- R11: After reset, `busy`=0, `core_rst`=0, `cfg_active`=0, and the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | DATA_W | Input stream data |
| s_tuser | input | 1 | Input frame start marker |
| s_tlast | input | 1 | Input line end marker |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted by the gate |
| m_tdata | output | DATA_W | Data toward the core |
| m_tuser | output | 1 | Frame start toward the core |
| m_tlast | output | 1 | Line end toward the core |
| m_tvalid | output | 1 | Beat valid toward the core |
| m_tready | input | 1 | Core ready to take a beat |
| o_tuser | input | 1 | Core output frame start (tap) |
| o_tlast | input | 1 | Core output line end (tap) |
| o_tvalid | input | 1 | Core output valid (tap) |
| o_tready | input | 1 | Downstream ready on core output (tap) |
| lines_per_frame | input | LINE_W | Output lines that make up one frame |
| rst_cycles | input | RST_W | Length of the core reset pulse in cycles |
| req_valid | input | 1 | Request strobe for a new parameter word |
| req_cfg | input | CFG_W | Requested parameter word |
| cfg_active | output | CFG_W | Parameter word presented to the core |
| core_rst | output | 1 | Reset to the processing core |
| busy | output | 1 | A parameter change is in progress |

## Verification
The gate signals `s_tready` and `m_tvalid` are due in the same cycle as the input change. The bench therefore drives on the falling edge and samples one time unit later, before the next rising edge. `busy` is due one edge after the request. `core_rst` is due two edges after the completing TLAST handshake, and `cfg_active` changes one edge later. Each of these results is checked at the first falling edge after the edge on which it is due.

The bench also checks the value one edge earlier where an early change would be a defect. This covers `core_rst` low after the first edge and `cfg_active` unchanged while the reset is rising. The reset length is measured by counting falling edges with `core_rst` high. The one-cycle settle gap is checked at the first falling edge with `core_rst` low, and the reopen at the edge after that.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic [2:0] {
    ST_OPEN   = 3'd0,
    ST_PEND   = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_RESET  = 3'd3,
    ST_SETTLE = 3'd4
  } fcg_state_e;
endpackage

// File: rtl/fcg_line_mon.sv
// Counts line ends on the core output and flags the beat that completes a frame.
module fcg_line_mon #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_rst,
  input  logic              o_tvalid,
  input  logic              o_tready,
  input  logic              o_tuser,
  input  logic              o_tlast,
  input  logic [LINE_W-1:0] lines_per_frame,
  output logic              frame_done
);
  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W-1:0] base;
  logic [LINE_W-1:0] nxt;
  logic              beat;

  always_comb begin
    beat       = o_tvalid && o_tready;
    base       = o_tuser ? '0 : cnt_q;
    nxt        = base + LINE_W'(o_tlast);
    frame_done = beat && o_tlast && (nxt == lines_per_frame);
  end

  always_ff @(posedge clk) begin
    if (rst || core_rst) begin
      cnt_q <= '0;
    end else if (beat) begin
      cnt_q <= frame_done ? '0 : nxt;
    end
  end
endmodule

// File: rtl/fcg_ctrl.sv
// Sequencer: pending -> drain -> core reset -> settle, plus outstanding-frame count.
module fcg_ctrl
  import fcg_pkg::*;
#(
  parameter int RST_W  = 8,
  parameter int OUTS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              s_tvalid,
  input  logic              s_tuser,
  input  logic              sof_in,
  input  logic              frame_done,
  input  logic [RST_W-1:0]  rst_cycles,
  output fcg_state_e        state,
  output logic [OUTS_W-1:0] outs_cnt,
  output logic              core_rst,
  output logic              busy
);
  localparam logic [RST_W-1:0]  TMR_ONE  = RST_W'(1);
  localparam logic [OUTS_W-1:0] OUTS_ONE = OUTS_W'(1);

  fcg_state_e        st_q, st_d;
  logic [RST_W-1:0]  tmr_q, tmr_d;
  logic [OUTS_W-1:0] outs_q;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    unique case (st_q)
      ST_OPEN:   if (req_valid) st_d = ST_PEND;
      ST_PEND:   if (s_tvalid && s_tuser) st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (outs_q == '0) begin
          st_d  = ST_RESET;
          tmr_d = (rst_cycles == '0) ? TMR_ONE : rst_cycles;
        end
      end
      ST_RESET: begin
        if (tmr_q == TMR_ONE) st_d = ST_SETTLE;
        else                  tmr_d = tmr_q - TMR_ONE;
      end
      ST_SETTLE: st_d = req_valid ? ST_PEND : ST_OPEN;
      default:   st_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OPEN;
      tmr_q    <= '0;
      core_rst <= 1'b0;
      busy     <= 1'b0;
    end else begin
      st_q     <= st_d;
      tmr_q    <= tmr_d;
      core_rst <= (st_d == ST_RESET);
      busy     <= (st_d != ST_OPEN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outs_q <= '0;
    end else if (sof_in && !frame_done) begin
      outs_q <= outs_q + OUTS_ONE;
    end else if (!sof_in && frame_done && (outs_q != '0)) begin
      outs_q <= outs_q - OUTS_ONE;
    end
  end

  assign state    = st_q;
  assign outs_cnt = outs_q;
endmodule

// File: rtl/fcg_cfg_regs.sv
// Shadow and active parameter registers; commit happens during core reset.
module fcg_cfg_regs #(
  parameter int             CFG_W   = 32,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CFG_W-1:0] req_cfg,
  input  logic             commit,
  output logic [CFG_W-1:0] cfg_active
);
  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] shadow_d;

  assign shadow_d = req_valid ? req_cfg : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q   <= CFG_RST;
      cfg_active <= CFG_RST;
    end else begin
      shadow_q <= shadow_d;
      if (commit) cfg_active <= shadow_d;
    end
  end
endmodule

// File: rtl/frame_cfg_gate.sv
module frame_cfg_gate
  import fcg_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CFG_W  = 32,
  parameter int LINE_W = 12,
  parameter int RST_W  = 8,
  parameter int OUTS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tuser,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tuser,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  input  logic              o_tuser,
  input  logic              o_tlast,
  input  logic              o_tvalid,
  input  logic              o_tready,
  input  logic [LINE_W-1:0] lines_per_frame,
  input  logic [RST_W-1:0]  rst_cycles,
  input  logic              req_valid,
  input  logic [CFG_W-1:0]  req_cfg,
  output logic [CFG_W-1:0]  cfg_active,
  output logic              core_rst,
  output logic              busy
);
  fcg_state_e        state;
  logic [OUTS_W-1:0] outs_cnt;
  logic              frame_done;
  logic              gate_pass;
  logic              sof_in;

  // Open when idle; while pending, pass everything except a frame start.
  always_comb begin
    gate_pass = (state == ST_OPEN) || ((state == ST_PEND) && !s_tuser);
    m_tvalid  = s_tvalid && gate_pass;
    s_tready  = m_tready && gate_pass;
    m_tdata   = s_tdata;
    m_tuser   = s_tuser;
    m_tlast   = s_tlast;
    sof_in    = m_tvalid && m_tready && s_tuser;
  end

  fcg_line_mon #(.LINE_W(LINE_W)) i_line_mon (
    .clk             (clk),
    .rst             (rst),
    .core_rst        (core_rst),
    .o_tvalid        (o_tvalid),
    .o_tready        (o_tready),
    .o_tuser         (o_tuser),
    .o_tlast         (o_tlast),
    .lines_per_frame (lines_per_frame),
    .frame_done      (frame_done)
  );

  fcg_ctrl #(.RST_W(RST_W), .OUTS_W(OUTS_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .s_tvalid   (s_tvalid),
    .s_tuser    (s_tuser),
    .sof_in     (sof_in),
    .frame_done (frame_done),
    .rst_cycles (rst_cycles),
    .state      (state),
    .outs_cnt   (outs_cnt),
    .core_rst   (core_rst),
    .busy       (busy)
  );

  fcg_cfg_regs #(.CFG_W(CFG_W), .CFG_RST('0)) i_cfg (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_cfg    (req_cfg),
    .commit     (core_rst),
    .cfg_active (cfg_active)
  );
endmodule

// File: rtl/fcg_chk.sv
module fcg_chk #(
  parameter int CFG_W  = 32,
  parameter int RST_W  = 8,
  parameter int OUTS_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tuser,
  input logic              core_rst,
  input logic              busy,
  input logic [CFG_W-1:0]  cfg_active,
  input logic [RST_W-1:0]  rst_cycles,
  input logic [OUTS_W-1:0] outs_cnt
);
  localparam int RUN_W = RST_W + 1;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_exp;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (core_rst) run_q <= run_q + RUN_W'(1);
    else               run_q <= '0;
  end

  assign run_exp = (rst_cycles == '0) ? RUN_W'(1) : {1'b0, rst_cycles};

  assert_lossless_R10: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready) == (m_tvalid && m_tready));

  assert_no_sof_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && m_tvalid) |-> !m_tuser);

  assert_drained_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> (outs_cnt == '0));

  assert_rst_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (run_q == run_exp));

  assert_cfg_in_reset_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_active != $past(cfg_active)) |-> $past(core_rst));

  assert_closed_in_rst_R6: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (!m_tvalid && !s_tready));

  assert_settle_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (busy && !s_tready && !m_tvalid));

  assert_busy_in_rst_R7: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> busy);
endmodule

bind frame_cfg_gate fcg_chk #(.CFG_W(CFG_W), .RST_W(RST_W), .OUTS_W(OUTS_W)) i_fcg_chk (
  .clk        (clk),
  .rst        (rst),
  .s_tvalid   (s_tvalid),
  .s_tready   (s_tready),
  .m_tvalid   (m_tvalid),
  .m_tready   (m_tready),
  .m_tuser    (m_tuser),
  .core_rst   (core_rst),
  .busy       (busy),
  .cfg_active (cfg_active),
  .rst_cycles (rst_cycles),
  .outs_cnt   (outs_cnt)
);

// File: tb/test_frame_cfg_gate.sv
`timescale 1ns/1ps
module test_frame_cfg_gate;
  localparam int DATA_W = 24;
  localparam int CFG_W  = 32;
  localparam int LINE_W = 12;
  localparam int RST_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] s_tdata = '0;
  logic              s_tuser = 1'b0, s_tlast = 1'b0, s_tvalid = 1'b0;
  logic              s_tready;
  logic [DATA_W-1:0] m_tdata;
  logic              m_tuser, m_tlast, m_tvalid;
  logic              m_tready = 1'b1;
  logic              o_tuser = 1'b0, o_tlast = 1'b0, o_tvalid = 1'b0, o_tready = 1'b1;
  logic [LINE_W-1:0] lines_per_frame = LINE_W'(3);
  logic [RST_W-1:0]  rst_cycles = RST_W'(4);
  logic              req_valid = 1'b0;
  logic [CFG_W-1:0]  req_cfg = '0;
  logic [CFG_W-1:0]  cfg_active;
  logic              core_rst, busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frame_cfg_gate #(.DATA_W(DATA_W), .CFG_W(CFG_W), .LINE_W(LINE_W), .RST_W(RST_W)) i_frame_cfg_gate (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .o_tuser(o_tuser), .o_tlast(o_tlast), .o_tvalid(o_tvalid), .o_tready(o_tready),
    .lines_per_frame(lines_per_frame), .rst_cycles(rst_cycles),
    .req_valid(req_valid), .req_cfg(req_cfg),
    .cfg_active(cfg_active), .core_rst(core_rst), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic obeat(input logic u, input logic l);
    @(negedge clk);
    o_tvalid = 1'b1; o_tuser = u; o_tlast = l;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 core_rst", 32'(core_rst), 0);
    chk("R11 cfg_active", cfg_active, 0);
    chk("R11 s_tready open", 32'(s_tready), 1);
  endtask

  task automatic t_pass;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 24'hA1B2C3; s_tuser = 1'b1; s_tlast = 1'b0;
    #1;
    chk("R1 m_tvalid", 32'(m_tvalid), 1);
    chk("R1 m_tdata", 32'(m_tdata), 32'h00A1B2C3);
    chk("R1 m_tuser", 32'(m_tuser), 1);
    m_tready = 1'b0;
    #1;
    chk("R1 s_tready follows m_tready", 32'(s_tready), 0);
    m_tready = 1'b1;
    @(negedge clk);
    s_tdata = 24'h000102; s_tuser = 1'b0; s_tlast = 1'b1;
    #1;
    chk("R1 m_tlast", 32'(m_tlast), 1);
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic t_request;
    @(negedge clk);
    req_valid = 1'b1; req_cfg = 32'h1111_0001;
    @(negedge clk);
    chk("R7 busy after request", 32'(busy), 1);
    req_cfg = 32'h2222_0002;
    @(negedge clk);
    req_valid = 1'b0;
    s_tvalid = 1'b1; s_tuser = 1'b0; s_tdata = 24'h0000AA;
    #1;
    chk("R2 in-frame beat passes", 32'(m_tvalid), 1);
    @(negedge clk);
    s_tuser = 1'b1; s_tdata = 24'h5F5F5F;
    #1;
    chk("R2 sof held s_tready", 32'(s_tready), 0);
    chk("R2 sof held m_tvalid", 32'(m_tvalid), 0);
    @(negedge clk);
    chk("R3 no reset while frame outstanding", 32'(core_rst), 0);
    chk("R5 cfg unchanged before reset", cfg_active, 0);
  endtask

  task automatic t_drain;
    int hi;
    obeat(1'b0, 1'b1);
    obeat(1'b0, 1'b1);
    obeat(1'b1, 1'b1);
    obeat(1'b0, 1'b1);
    @(negedge clk);
    o_tvalid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 output sof restarts line count", 32'(core_rst), 0);
    end
    obeat(1'b0, 1'b1);
    @(negedge clk);
    o_tvalid = 1'b0; o_tlast = 1'b0;
    chk("R3 reset not yet after one edge", 32'(core_rst), 0);
    @(negedge clk);
    chk("R3 reset two edges after last tlast", 32'(core_rst), 1);
    chk("R5 cfg not yet loaded", cfg_active, 0);
    hi = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!core_rst) break;
      hi++;
    end
    chk("R4 reset length", 32'(hi), 4);
    chk("R6 settle busy", 32'(busy), 1);
    chk("R6 settle gate closed", 32'(m_tvalid), 0);
    chk("R8 last request applied", cfg_active, 32'h2222_0002);
    @(negedge clk);
    chk("R6 reopened busy", 32'(busy), 0);
    chk("R6 reopened sof passes", 32'(m_tvalid), 1);
    chk("R6 reopened beat is sof", 32'(m_tuser), 1);
    @(negedge clk);
    s_tvalid = 1'b0; s_tuser = 1'b0;
  endtask

  task automatic t_short_and_late;
    bit seen;
    rst_cycles = '0;
    @(negedge clk);
    req_valid = 1'b1; req_cfg = 32'h3333_0003;
    @(negedge clk);
    req_valid = 1'b0;
    s_tvalid = 1'b1; s_tuser = 1'b1; s_tdata = 24'h123456;
    obeat(1'b1, 1'b0);
    obeat(1'b0, 1'b1);
    obeat(1'b0, 1'b1);
    obeat(1'b0, 1'b1);
    @(negedge clk);
    o_tvalid = 1'b0; o_tlast = 1'b0; o_tuser = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (core_rst) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R3 reset after output frame", 32'(seen), 1);
    req_valid = 1'b1; req_cfg = 32'h4444_0004;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 zero length gives one cycle", 32'(core_rst), 0);
    chk("R8 request during reset applied", cfg_active, 32'h4444_0004);
    req_valid = 1'b1; req_cfg = 32'h5555_0005;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 settle request keeps busy", 32'(busy), 1);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (core_rst) begin seen = 1'b1; break; end
    end
    chk("R8 settle request starts new reset", 32'(seen), 1);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!busy) begin seen = 1'b1; break; end
    end
    chk("R7 busy clears at reopen", 32'(seen), 1);
    chk("R8 settle request applied", cfg_active, 32'h5555_0005);
    chk("R10 held sof delivered", 32'(m_tvalid && m_tuser && (m_tdata == 24'h123456)), 1);
    @(negedge clk);
    s_tvalid = 1'b0; s_tuser = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pass();
    t_request();
    t_drain();
    t_short_and_late();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule